// File: doc/BRIEF.md
# Compressed Quadrant-1 Instruction Expander

This block turns a single 16-bit compressed RISC-V instruction from quadrant 1 (the encodings whose two lowest bits are `01`) into the equivalent 32-bit base-ISA word. It collects the scattered immediate bits of each compressed format and rebuilds them as sign-extended I, U, R, J or B immediates. It also maps the three-bit register fields onto x8..x15. Alongside the word it returns a valid flag and an illegal flag.

The `XLEN` parameter selects 32-bit or 64-bit behaviour. That choice changes how funct3 `001` is read, whether the word-sized register operations exist, and whether a shift amount of 32 or more is allowed. The `REG_OUT` parameter adds an output register so the block can sit at a pipeline boundary. Hints expand to the canonical no-operation. Reserved encodings, and any input outside quadrant 1, raise the illegal flag.

Top module: `c1_expander`

## Requirements
- R1: An input with valid set and bits 1:0 not equal to `01`, or any reserved encoding, sets the illegal flag and drives the output word to `32'h0000_0000`.
- R2: While the input valid is low, the output valid, the illegal flag and the output word are all zero. Reset clears the registered outputs.
- R3: funct3 `000` expands to `ADDI rd,rd,imm`. funct3 `010` expands to `ADDI rd,x0,imm`. funct3 `100` with bits 11:10 = `10` expands to `ANDI rd',rd',imm`. imm is the sign-extended value of {bit 12, bits 6:2}, rd is bits 11:7, and rd' is x8 plus bits 9:7.
- R4: The following hints produce the no-operation word `32'h0000_0013` and are not flagged illegal: funct3 `000` with a zero immediate; funct3 `010` with rd = x0; funct3 `011` with rd = x0 and a nonzero immediate.
- R5: funct3 `001` expands to `JAL x1,offset` when XLEN is 32, using the jump offset of R10. When XLEN is 64 it expands to `ADDIW rd,rd,imm` (opcode `0011011`).
- R6: funct3 `011` with rd = x2 expands to `ADDI x2,x2,imm`. imm is the sign-extended value of {bit 12, bits 4:3, bit 5, bit 2, bit 6} times 16.
- R7: funct3 `011` with rd other than x2 expands to `LUI rd,imm`, with the sign-extended {bit 12, bits 6:2} in word bits 31:12. A zero immediate is illegal.
- R8: funct3 `100` with bits 11:10 = `00` gives `SRLI`, and `01` gives `SRAI` (word bit 30 set). Both use rd' as source and destination, with shift amount {bit 12, bits 6:2}. When XLEN is 32, a set bit 12 is illegal.
- R9: funct3 `100` with bits 11:10 = `11` is chosen by {bit 12, bits 6:5}: `000` SUB, `001` XOR, `010` OR, `011` AND, `100` SUBW, `101` ADDW. Source 2 is x8 plus bits 4:2. Codes `110` and `111` are illegal, and so is every code with bit 12 set when XLEN is 32.
- R10: funct3 `101` expands to `JAL x0,offset`. offset is the sign-extended value of {bit 12, bit 8, bits 10:9, bit 6, bit 7, bit 2, bit 11, bits 5:3} times 2.
- R11: funct3 `110` expands to `BEQ rs1',x0,offset` and `111` to `BNE rs1',x0,offset`. offset is the sign-extended value of {bit 12, bits 6:5, bit 2, bits 11:10, bits 4:3} times 2.
- R12: With `REG_OUT` = 1, all outputs follow the input by exactly one clock. With `REG_OUT` = 0, they follow it within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input instruction is present |
| in_instr | input | 16 | Compressed instruction |
| out_valid | output | 1 | Expanded word is present |
| out_instr | output | 32 | Expanded 32-bit instruction, zero when illegal or idle |
| out_illegal | output | 1 | Input is outside quadrant 1 or is a reserved encoding |

## Verification
Hint handling and reserved-encoding detection can both apply to the same input. This happens with funct3 `011` and rd = x0: a nonzero immediate makes the input a hint, while a zero immediate makes it reserved. The stack-pointer form with rd = x2 bypasses both checks. The bench provokes this overlap with directed words and with a full sweep of all 16384 quadrant-1 codes, run against both XLEN settings. Each result is compared with an independently written expansion that gives the reserved case priority and yields either the no-operation word or the illegal flag, never both.

// File: rtl/c1_pkg.sv
package c1_pkg;

   localparam logic [6:0] OP_IMM    = 7'b0010011;
   localparam logic [6:0] OP_IMM32  = 7'b0011011;
   localparam logic [6:0] OP_LUI    = 7'b0110111;
   localparam logic [6:0] OP_REG    = 7'b0110011;
   localparam logic [6:0] OP_REG32  = 7'b0111011;
   localparam logic [6:0] OP_JAL    = 7'b1101111;
   localparam logic [6:0] OP_BRANCH = 7'b1100011;

   localparam logic [2:0] F3_ADD = 3'b000;
   localparam logic [2:0] F3_XOR = 3'b100;
   localparam logic [2:0] F3_OR  = 3'b110;
   localparam logic [2:0] F3_AND = 3'b111;
   localparam logic [2:0] F3_SR  = 3'b101;

   localparam logic [6:0] F7_BASE = 7'b0000000;
   localparam logic [6:0] F7_ALT  = 7'b0100000;

   localparam logic [4:0] REG_ZERO = 5'd0;
   localparam logic [4:0] REG_RA   = 5'd1;
   localparam logic [4:0] REG_SP   = 5'd2;

   localparam logic [31:0] NOP_WORD = 32'h0000_0013;

   typedef struct packed {
      logic [1:0]  quad;
      logic [2:0]  f3;
      logic [4:0]  rd;
      logic [4:0]  rs1p;
      logic [4:0]  rs2p;
      logic [11:0] imm6;
      logic [11:0] imm_sp;
      logic [19:0] imm_lui;
      logic [5:0]  shamt;
      logic [1:0]  sel2;
      logic [2:0]  rsel;
      logic [20:1] off_j;
      logic [12:1] off_b;
   } c1_fields_t;

   function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                         input logic [2:0] f3, input logic [4:0] rd,
                                         input logic [6:0] op);
      return {imm, rs1, f3, rd, op};
   endfunction

   function automatic logic [31:0] enc_u(input logic [19:0] imm, input logic [4:0] rd,
                                         input logic [6:0] op);
      return {imm, rd, op};
   endfunction

   function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                         input logic [4:0] rs1, input logic [2:0] f3,
                                         input logic [4:0] rd, input logic [6:0] op);
      return {f7, rs2, rs1, f3, rd, op};
   endfunction

   function automatic logic [31:0] enc_j(input logic [20:1] o, input logic [4:0] rd);
      return {o[20], o[10:1], o[11], o[19:12], rd, OP_JAL};
   endfunction

   function automatic logic [31:0] enc_b(input logic [12:1] o, input logic [4:0] rs2,
                                         input logic [4:0] rs1, input logic [2:0] f3);
      return {o[12], o[10:5], rs2, rs1, f3, o[4:1], o[11], OP_BRANCH};
   endfunction

endpackage

// File: rtl/c1_field_gather.sv
module c1_field_gather
   import c1_pkg::*;
(
   input  logic [15:0] instr,
   output c1_fields_t  fields
);
   logic s;
   assign s = instr[12];

   always_comb begin
      fields.quad    = instr[1:0];
      fields.f3      = instr[15:13];
      fields.rd      = instr[11:7];
      fields.rs1p    = {2'b01, instr[9:7]};
      fields.rs2p    = {2'b01, instr[4:2]};
      fields.imm6    = {{6{s}}, s, instr[6:2]};
      fields.imm_sp  = {{2{s}}, s, instr[4:3], instr[5], instr[2], instr[6], 4'b0000};
      fields.imm_lui = {{14{s}}, s, instr[6:2]};
      fields.shamt   = {s, instr[6:2]};
      fields.sel2    = instr[11:10];
      fields.rsel    = {s, instr[6:5]};
      fields.off_j   = {{9{s}}, s, instr[8], instr[10:9], instr[6], instr[7],
                        instr[2], instr[11], instr[5:3]};
      fields.off_b   = {{4{s}}, s, instr[6:5], instr[2], instr[11:10], instr[4:3]};
   end
endmodule

// File: rtl/c1_expand_core.sv
module c1_expand_core
   import c1_pkg::*;
#(
   parameter int XLEN = 64
)(
   input  c1_fields_t  f,
   output logic [31:0] word,
   output logic        bad
);
   localparam bit HAS_W = (XLEN == 64);

   logic [31:0] w_f3_001;

   generate
      if (HAS_W) begin : g_addw_variant
         assign w_f3_001 = enc_i(f.imm6, f.rd, F3_ADD, f.rd, OP_IMM32);
      end else begin : g_link_variant
         assign w_f3_001 = enc_j(f.off_j, REG_RA);
      end
   endgenerate

   logic [31:0] raw;
   logic        rsv;

   always_comb begin
      raw = NOP_WORD;
      rsv = 1'b0;
      if (f.quad != 2'b01) begin
         rsv = 1'b1;
      end else begin
         unique case (f.f3)
            3'b000: begin
               if (f.imm6 != 12'd0) raw = enc_i(f.imm6, f.rd, F3_ADD, f.rd, OP_IMM);
            end
            3'b001: raw = w_f3_001;
            3'b010: begin
               if (f.rd != REG_ZERO) raw = enc_i(f.imm6, REG_ZERO, F3_ADD, f.rd, OP_IMM);
            end
            3'b011: begin
               if (f.rd == REG_SP)           raw = enc_i(f.imm_sp, REG_SP, F3_ADD, REG_SP, OP_IMM);
               else if (f.imm6 == 12'd0)     rsv = 1'b1;
               else if (f.rd != REG_ZERO)    raw = enc_u(f.imm_lui, f.rd, OP_LUI);
            end
            3'b100: begin
               unique case (f.sel2)
                  2'b00, 2'b01: begin
                     if (!HAS_W && f.shamt[5]) rsv = 1'b1;
                     else raw = {1'b0, f.sel2[0], 4'b0000, f.shamt, f.rs1p, F3_SR, f.rs1p, OP_IMM};
                  end
                  2'b10: raw = enc_i(f.imm6, f.rs1p, F3_AND, f.rs1p, OP_IMM);
                  default: begin
                     unique case (f.rsel)
                        3'b000: raw = enc_r(F7_ALT,  f.rs2p, f.rs1p, F3_ADD, f.rs1p, OP_REG);
                        3'b001: raw = enc_r(F7_BASE, f.rs2p, f.rs1p, F3_XOR, f.rs1p, OP_REG);
                        3'b010: raw = enc_r(F7_BASE, f.rs2p, f.rs1p, F3_OR,  f.rs1p, OP_REG);
                        3'b011: raw = enc_r(F7_BASE, f.rs2p, f.rs1p, F3_AND, f.rs1p, OP_REG);
                        3'b100: begin
                           if (HAS_W) raw = enc_r(F7_ALT, f.rs2p, f.rs1p, F3_ADD, f.rs1p, OP_REG32);
                           else       rsv = 1'b1;
                        end
                        3'b101: begin
                           if (HAS_W) raw = enc_r(F7_BASE, f.rs2p, f.rs1p, F3_ADD, f.rs1p, OP_REG32);
                           else       rsv = 1'b1;
                        end
                        default: rsv = 1'b1;
                     endcase
                  end
               endcase
            end
            3'b101: raw = enc_j(f.off_j, REG_ZERO);
            default: raw = enc_b(f.off_b, REG_ZERO, f.rs1p, {2'b00, f.f3[0]});
         endcase
      end
   end

   assign word = rsv ? 32'd0 : raw;
   assign bad  = rsv;
endmodule

// File: rtl/c1_out_stage.sv
module c1_out_stage #(
   parameter bit REG_OUT = 1'b1,
   parameter int W       = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_valid,
   input  logic [W-1:0] d_word,
   input  logic         d_bad,
   output logic         q_valid,
   output logic [W-1:0] q_word,
   output logic         q_bad
);
   generate
      if (REG_OUT) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_valid <= 1'b0;
               q_word  <= '0;
               q_bad   <= 1'b0;
            end else begin
               q_valid <= d_valid;
               q_word  <= d_word;
               q_bad   <= d_bad;
            end
         end
      end else begin : g_wire
         assign q_valid = d_valid;
         assign q_word  = d_word;
         assign q_bad   = d_bad;
      end
   endgenerate
endmodule

// File: rtl/c1_expander.sv
module c1_expander
   import c1_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter bit REG_OUT = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [15:0] in_instr,
   output logic        out_valid,
   output logic [31:0] out_instr,
   output logic        out_illegal
);
   localparam int WORD_W = 32;

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("c1_expander: XLEN must be 32 or 64");
      end
   endgenerate

   c1_fields_t        fields;
   logic [WORD_W-1:0] core_word;
   logic              core_bad;
   logic [WORD_W-1:0] gated_word;
   logic              gated_bad;

   c1_field_gather u_gather (
      .instr  (in_instr),
      .fields (fields)
   );

   c1_expand_core #(.XLEN(XLEN)) u_core (
      .f    (fields),
      .word (core_word),
      .bad  (core_bad)
   );

   assign gated_word = in_valid ? core_word : '0;
   assign gated_bad  = in_valid & core_bad;

   c1_out_stage #(.REG_OUT(REG_OUT), .W(WORD_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (in_valid),
      .d_word  (gated_word),
      .d_bad   (gated_bad),
      .q_valid (out_valid),
      .q_word  (out_instr),
      .q_bad   (out_illegal)
   );
endmodule

// File: rtl/c1_expander_chk.sv
module c1_expander_chk #(
   parameter bit REG_OUT = 1'b1
)(
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [15:0] in_instr,
   input logic        out_valid,
   input logic [31:0] out_instr,
   input logic        out_illegal
);
   logic        ref_v;
   logic [15:0] ref_i;

   generate
      if (REG_OUT) begin : g_track
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ref_v <= 1'b0;
               ref_i <= 16'd0;
            end else begin
               ref_v <= in_valid;
               ref_i <= in_instr;
            end
         end
      end else begin : g_direct
         assign ref_v = in_valid;
         assign ref_i = in_instr;
      end
   endgenerate

   logic q1;
   assign q1 = ref_v && (ref_i[1:0] == 2'b01);

   p_quadrant_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_v && ref_i[1:0] != 2'b01) |-> (out_illegal && out_instr == 32'd0));

   p_illegal_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (out_instr == 32'd0 && out_valid));

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_illegal && out_instr == 32'd0));

   p_addi_hint_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (q1 && ref_i[15:13] == 3'b000 && ref_i[12] == 1'b0 && ref_i[6:2] == 5'd0)
      |-> (out_instr == 32'h0000_0013 && !out_illegal));

   p_lui_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q1 && ref_i[15:13] == 3'b011 && ref_i[11:7] != 5'd2 && ref_i[12] == 1'b0 && ref_i[6:2] == 5'd0)
      |-> out_illegal);

   p_jump_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (q1 && ref_i[15:13] == 3'b101) |-> (out_instr[11:0] == 12'h06F && !out_illegal));

   p_branch_form_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (q1 && ref_i[15:14] == 2'b11)
      |-> (out_instr[6:0] == 7'b1100011 && out_instr[24:20] == 5'd0 && out_instr[14:12] == {2'b00, ref_i[13]}));

   p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == ref_v);
endmodule

bind c1_expander c1_expander_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_instr    (in_instr),
   .out_valid   (out_valid),
   .out_instr   (out_instr),
   .out_illegal (out_illegal)
);

// File: tb/c1_expander_bench.sv
module c1_expander_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_instr = 16'd0;

   logic        v64, v32, i64, i32;
   logic [31:0] w64, w32;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;

   logic [33:0] cap64, cap32;

   always #(CLK_PERIOD/2) clk = ~clk;

   c1_expander #(.XLEN(64), .REG_OUT(1'b1)) u_c1_expander (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
      .out_valid(v64), .out_instr(w64), .out_illegal(i64));

   c1_expander #(.XLEN(32), .REG_OUT(1'b0)) u_c1_expander_rv32 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
      .out_valid(v32), .out_instr(w32), .out_illegal(i32));

   // independent reference expansion, arithmetic on integers
   function automatic logic [31:0] pk_i(input int imm, input int rs1, input int f3,
                                        input int rd, input int op);
      logic [31:0] u;
      u = ((imm & 32'hFFF) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op;
      return u;
   endfunction

   function automatic logic [31:0] pk_r(input int f7, input int rs2, input int rs1,
                                        input int f3, input int rd, input int op);
      logic [31:0] u;
      u = (f7 << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op;
      return u;
   endfunction

   function automatic logic [31:0] pk_j(input int off, input int rd);
      logic [31:0] u;
      logic [31:0] r;
      u = off;
      r = rd;
      return {u[20], u[10:1], u[11], u[19:12], r[4:0], 7'h6F};
   endfunction

   function automatic logic [31:0] pk_b(input int off, input int rs1, input int f3);
      logic [31:0] u;
      logic [31:0] a;
      logic [31:0] f;
      u = off;
      a = rs1;
      f = f3;
      return {u[12], u[10:5], 5'd0, a[4:0], f[2:0], u[4:1], u[11], 7'h63};
   endfunction

   function automatic void ref_exp(input logic [15:0] c, input int xl,
                                   output logic [31:0] w, output logic ill);
      int imm6, spi, jo, bo, rd, rp, rq, sh;
      imm6 = int'(c[6:2]) - (c[12] ? 32 : 0);
      spi  = (c[12] ? -512 : 0) + int'(c[4:3]) * 128 + int'(c[5]) * 64
             + int'(c[2]) * 32 + int'(c[6]) * 16;
      jo   = (c[12] ? -2048 : 0) + int'(c[8]) * 1024 + int'(c[10:9]) * 256
             + int'(c[6]) * 128 + int'(c[7]) * 64 + int'(c[2]) * 32
             + int'(c[11]) * 16 + int'(c[5:3]) * 2;
      bo   = (c[12] ? -256 : 0) + int'(c[6:5]) * 64 + int'(c[2]) * 32
             + int'(c[11:10]) * 8 + int'(c[4:3]) * 2;
      rd = int'(c[11:7]);
      rp = 8 + int'(c[9:7]);
      rq = 8 + int'(c[4:2]);
      sh = int'({c[12], c[6:2]});
      w = 32'd0;
      ill = 1'b0;
      if (c[1:0] != 2'b01) ill = 1'b1;
      else begin
         case (c[15:13])
            3'd0: w = (imm6 == 0) ? 32'h13 : pk_i(imm6, rd, 0, rd, 32'h13);
            3'd1: w = (xl == 32) ? pk_j(jo, 1) : pk_i(imm6, rd, 0, rd, 32'h1B);
            3'd2: w = (rd == 0) ? 32'h13 : pk_i(imm6, 0, 0, rd, 32'h13);
            3'd3: begin
               if (rd == 2) w = pk_i(spi, 2, 0, 2, 32'h13);
               else if (imm6 == 0) ill = 1'b1;
               else if (rd == 0) w = 32'h13;
               else w = (imm6 << 12) | (rd << 7) | 32'h37;
            end
            3'd4: begin
               case (c[11:10])
                  2'd0, 2'd1: begin
                     if (xl == 32 && c[12]) ill = 1'b1;
                     else w = (((c[10] ? 32'h400 : 32'h0) | sh) << 20) | (rp << 15)
                              | (5 << 12) | (rp << 7) | 32'h13;
                  end
                  2'd2: w = pk_i(imm6, rp, 7, rp, 32'h13);
                  default: begin
                     case ({c[12], c[6:5]})
                        3'd0: w = pk_r(32, rq, rp, 0, rp, 32'h33);
                        3'd1: w = pk_r(0, rq, rp, 4, rp, 32'h33);
                        3'd2: w = pk_r(0, rq, rp, 6, rp, 32'h33);
                        3'd3: w = pk_r(0, rq, rp, 7, rp, 32'h33);
                        3'd4: if (xl == 32) ill = 1'b1; else w = pk_r(32, rq, rp, 0, rp, 32'h3B);
                        3'd5: if (xl == 32) ill = 1'b1; else w = pk_r(0, rq, rp, 0, rp, 32'h3B);
                        default: ill = 1'b1;
                     endcase
                  end
               endcase
            end
            3'd5: w = pk_j(jo, 0);
            default: w = pk_b(bo, rp, int'(c[13]));
         endcase
      end
      if (ill) w = 32'd0;
   endfunction

   function automatic string tag_of(input logic [15:0] c);
      if (c[1:0] != 2'b01) return "R1";
      case (c[15:13])
         3'd0: return ({c[12], c[6:2]} == 6'd0) ? "R4" : "R3";
         3'd1: return "R5";
         3'd2: return (c[11:7] == 5'd0) ? "R4" : "R3";
         3'd3: return (c[11:7] == 5'd2) ? "R6" : "R7";
         3'd4: return (c[11:10] == 2'd2) ? "R3" : (c[11:10] == 2'd3) ? "R9" : "R8";
         3'd5: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [33:0] act, input logic [33:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // drive one input for one cycle; check the combinational RV32 copy in the
   // same half cycle and the registered RV64 copy after the next rising edge
   task automatic step(input logic v, input logic [15:0] c, input string tag);
      logic [31:0] e64, e32;
      logic x64, x32;
      ref_exp(c, 64, e64, x64);
      ref_exp(c, 32, e32, x32);
      if (!v) begin
         e64 = 32'd0; e32 = 32'd0; x64 = 1'b0; x32 = 1'b0;
      end
      @(negedge clk);
      in_valid = v;
      in_instr = c;
      #1;
      cap32 = {v32, i32, w32};
      chk(tag, "rv32", cap32, {v, x32, e32});
      @(posedge clk);
      #1;
      cap64 = {v64, i64, w64};
      chk(tag, "rv64", cap64, {v, x64, e64});
   endtask

   task automatic t_reset;
      in_valid = 1'b1;
      in_instr = 16'h557D;
      repeat (3) @(posedge clk);
      #1;
      chk("R2", "reset", {v64, i64, w64}, 34'd0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_quadrant;
      step(1'b1, 16'h0000, "R1");
      chk("R1", "q0 word", cap64, {1'b1, 1'b1, 32'd0});
      step(1'b1, 16'hFFFE, "R1");
      chk("R1", "q2 word", cap32, {1'b1, 1'b1, 32'd0});
   endtask

   task automatic t_idle;
      step(1'b0, 16'h0000, "R2");
      chk("R2", "idle illegal input", cap64, 34'd0);
      step(1'b0, 16'h557D, "R2");
      chk("R2", "idle legal input", cap32, 34'd0);
   endtask

   task automatic t_imm_ops;
      step(1'b1, 16'h557D, "R3");
      chk("R3", "li x10,-1", cap64, {2'b10, 32'hFFF0_0513});
      chk("R3", "li x10,-1", cap32, {2'b10, 32'hFFF0_0513});
      step(1'b1, 16'h9BFD, "R3");
   endtask

   task automatic t_hints;
      step(1'b1, 16'h0001, "R4");
      chk("R4", "addi zero imm", cap64, {2'b10, 32'h0000_0013});
      step(1'b1, 16'h4015, "R4");
      chk("R4", "li to x0", cap32, {2'b10, 32'h0000_0013});
      step(1'b1, 16'h6005, "R4");
      chk("R4", "lui to x0", cap64, {2'b10, 32'h0000_0013});
   endtask

   task automatic t_f3_001;
      step(1'b1, 16'h2085, "R5");
      chk("R5", "addiw rv64", cap64, {2'b10, 32'h0010_809B});
      chk("R5", "jal x1 rv32", cap32, {2'b10, 32'h0600_00EF});
   endtask

   task automatic t_sp_and_lui;
      step(1'b1, 16'h6105, "R6");
      chk("R6", "addi sp,+32", cap64, {2'b10, 32'h0201_0113});
      step(1'b1, 16'h717D, "R6");
      step(1'b1, 16'h6285, "R7");
      chk("R7", "lui x5,1", cap32, {2'b10, 32'h0000_12B7});
      step(1'b1, 16'h6281, "R7");
      chk("R7", "lui zero imm", cap64, {2'b11, 32'd0});
      step(1'b1, 16'h6001, "R7");
      chk("R7", "x0 zero imm", cap32, {2'b11, 32'd0});
   endtask

   task automatic t_shifts;
      step(1'b1, 16'h9005, "R8");
      chk("R8", "srli 33 rv64", cap64, {2'b10, 32'h0214_5413});
      chk("R8", "srli 33 rv32", cap32, {2'b11, 32'd0});
      step(1'b1, 16'h847D, "R8");
   endtask

   task automatic t_regreg;
      step(1'b1, 16'h9C05, "R9");
      chk("R9", "subw rv64", cap64, {2'b10, 32'h4094_043B});
      chk("R9", "subw rv32", cap32, {2'b11, 32'd0});
      step(1'b1, 16'h9C41, "R9");
      chk("R9", "reserved 110", cap64, {2'b11, 32'd0});
      step(1'b1, 16'h8C0D, "R9");
   endtask

   task automatic t_jumps_branches;
      step(1'b1, 16'hA001, "R10");
      chk("R10", "j 0", cap64, {2'b10, 32'h0000_006F});
      step(1'b1, 16'hBFFD, "R10");
      step(1'b1, 16'hC001, "R11");
      chk("R11", "beqz x8,0", cap32, {2'b10, 32'h0004_0063});
      step(1'b1, 16'hFFFD, "R11");
   endtask

   task automatic t_latency;
      step(1'b1, 16'hA001, "R12");
      @(negedge clk);
      in_valid = 1'b1;
      in_instr = 16'h557D;
      #1;
      chk("R12", "reg holds prior", {v64, i64, w64}, {2'b10, 32'h0000_006F});
      chk("R12", "comb follows now", {v32, i32, w32}, {2'b10, 32'hFFF0_0513});
      @(posedge clk);
      #1;
      chk("R12", "reg takes new", {v64, i64, w64}, {2'b10, 32'hFFF0_0513});
   endtask

   task automatic t_sweep;
      for (int k = 0; k < 16384; k++) begin
         logic [31:0] kk;
         logic [15:0] c;
         kk = k;
         c = {kk[13:0], 2'b01};
         step(1'b1, c, tag_of(c));
      end
   endtask

   initial begin : watchdog
      while (cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      t_reset();
      t_quadrant();
      t_idle();
      t_imm_ops();
      t_hints();
      t_f3_001();
      t_sp_and_lui();
      t_shifts();
      t_regreg();
      t_jumps_branches();
      t_latency();
      t_sweep();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule